// File: doc/BRIEF.md
# Four-Stage Pipeline Stall Controller

This block holds the control and buffer logic of an in-order pipeline with four stages: fetch, decode, execute and write. Three pipeline buffers sit between them: the fetch-to-decode buffer, the decode-to-execute buffer and the execute-to-write buffer. Each instruction is an abstract token. A token carries an identifier and the number of cycles it needs in execute. Most tokens spend a single cycle in execute. A long operation, such as a divide, stays in execute for several cycles.

While a long operation is in execute, the controller freezes the two front buffers and refuses new tokens at fetch. It also clears the valid bit of the execute-to-write buffer, so the write stage receives a do-nothing bubble. Only one token is ever in execute, and tokens retire in the order they were accepted.

The execute stage is driven by a small state machine with two states:
- `ST_FLOW`: execute finishes its token this cycle, or execute is empty.
- `ST_HOLD`: a multi-cycle token still has cycles left to run.

The transitions are:
- **enter_long**: `ST_FLOW` to `ST_HOLD`, when a token with latency above one moves into execute. A down-counter is loaded with latency minus one.
- **count**: `ST_HOLD` to `ST_HOLD`, while the counter is above one. The counter decrements each cycle.
- **finish**: `ST_HOLD` to `ST_FLOW`, when the counter reaches one.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: After reset, `ret_valid`, `exec_busy`, `hold_fd` and `hold_de` are low and `in_ready` is high.
- R2: A token with latency 1, or latency 0 (treated as 1), spends exactly one cycle in execute.
  - Accepted with no stall, it appears on `ret_valid`/`ret_id` in the cycle after the second clock edge following acceptance.
- R3: A token with latency L greater than 1 stays in execute for L cycles. In each of the cycles after the first of those, the write stage receives a bubble: `ret_valid` is low.
- R4: The decode-to-execute buffer keeps its token unchanged while execute is busy. The token that retires therefore carries the identifier it entered execute with.
- R5: `in_ready` is low, and `hold_fd` and `hold_de` are high, in exactly the cycles in which execute is still busy with a multi-cycle token. In those cycles the fetch-to-decode buffer keeps its contents.
- R6: Tokens retire in acceptance order, one at a time. Take a continuous stream whose first token is accepted at edge 0, with latencies L0, L1, and so on. Token i is visible at the write stage in the cycle after edge 1 + L0 + ... + Li.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A token is offered at fetch |
| in_id | input | ID_W | Identifier of the offered token |
| in_lat | input | LAT_W | Execute cycles of the offered token (0 is treated as 1) |
| in_ready | output | 1 | Fetch takes the offered token at this edge |
| hold_fd | output | 1 | Hold on the fetch-to-decode buffer |
| hold_de | output | 1 | Hold on the decode-to-execute buffer |
| exec_busy | output | 1 | Execute still has cycles left on its current token |
| ret_valid | output | 1 | The write stage retires a token this cycle; low means bubble |
| ret_id | output | ID_W | Identifier of the retiring token |

## Verification
Cycle c is the interval after edge c, counting from the edge that accepts the first token. Token i starts execute in cycle s_i = 1 + L0 + ... + L(i-1). Execute stays busy from s_i through s_i + Li - 2, and the token retires in cycle s_i + Li.

The bench derives these cycle numbers from the latencies alone. It samples every output at the falling edge in the middle of each cycle, and compares `ret_valid`, `ret_id`, `in_ready` and both holds against the schedule. It sweeps all three-token streams with latencies 0 to 3.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
    // Execute-stage control states.
    typedef enum logic {
        ST_FLOW = 1'b0,  // execute finishes its token this cycle, or is empty
        ST_HOLD = 1'b1   // a multi-cycle token still has cycles to run
    } exec_state_t;
endpackage

// File: rtl/pipe_buf.sv
// One pipeline buffer: a valid bit plus a payload, frozen while hold is high.
module pipe_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         ld_valid,
    input  logic [W-1:0] ld_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (!hold) begin
            q_valid <= ld_valid;
            q_data  <= ld_data;
        end
    end
endmodule

// File: rtl/exec_ctrl.sv
// Execute-stage state machine with its down-counter of remaining cycles.
module exec_ctrl
    import pipe_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,      // a token moves into execute at this edge
    input  logic [LAT_W-1:0] enter_lat,  // its execute latency
    output logic             busy
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    exec_state_t      st, st_n;
    logic [LAT_W-1:0] cnt, cnt_n;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_FLOW;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // Next state and counter.
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_FLOW: begin
                // enter_long
                if (enter && (enter_lat > ONE)) begin
                    st_n  = ST_HOLD;
                    cnt_n = enter_lat - ONE;
                end
            end
            ST_HOLD: begin
                // count, or finish once the counter reaches one
                cnt_n = cnt - ONE;
                if (cnt == ONE) st_n = ST_FLOW;
            end
            default: st_n = ST_FLOW;
        endcase
    end

    // Outputs.
    always_comb begin
        busy = (st == ST_HOLD);
    end
endmodule

// File: rtl/pipe_stall_ctrl.sv
// Stall controller for a fetch/decode/execute/write pipeline.
module pipe_stall_ctrl #(
    parameter int ID_W  = 4,
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ID_W-1:0]  in_id,
    input  logic [LAT_W-1:0] in_lat,
    output logic             in_ready,
    output logic             hold_fd,
    output logic             hold_de,
    output logic             exec_busy,
    output logic             ret_valid,
    output logic [ID_W-1:0]  ret_id
);
    localparam int TOK_W = ID_W + LAT_W;

    logic             b1_valid, b2_valid;
    logic [TOK_W-1:0] b1_q, b2_q;
    logic [ID_W-1:0]  b2_id;
    logic [LAT_W-1:0] b1_lat, b2_lat;
    logic             busy;

    assign b1_lat = b1_q[TOK_W-1:ID_W];
    assign b2_lat = b2_q[TOK_W-1:ID_W];
    assign b2_id  = b2_q[ID_W-1:0];

    // Fetch into the fetch-to-decode buffer; frozen while execute is busy.
    pipe_buf #(.W(TOK_W)) u_b1 (
        .clk(clk), .rst_n(rst_n), .hold(busy),
        .ld_valid(in_valid), .ld_data({in_lat, in_id}),
        .q_valid(b1_valid), .q_data(b1_q)
    );

    // Decode into the decode-to-execute buffer; kept intact until execute finishes.
    pipe_buf #(.W(TOK_W)) u_b2 (
        .clk(clk), .rst_n(rst_n), .hold(busy),
        .ld_valid(b1_valid), .ld_data(b1_q),
        .q_valid(b2_valid), .q_data(b2_q)
    );

    // Execute into the execute-to-write buffer; a cleared valid bit is a bubble.
    pipe_buf #(.W(ID_W)) u_b3 (
        .clk(clk), .rst_n(rst_n), .hold(1'b0),
        .ld_valid(b2_valid && !busy), .ld_data(b2_id),
        .q_valid(ret_valid), .q_data(ret_id)
    );

    exec_ctrl #(.LAT_W(LAT_W)) u_exec (
        .clk(clk), .rst_n(rst_n),
        .enter(b1_valid && !busy), .enter_lat(b1_lat),
        .busy(busy)
    );

    assign in_ready  = !busy;
    assign hold_fd   = busy;
    assign hold_de   = busy;
    assign exec_busy = busy;
endmodule

// File: rtl/pipe_stall_ctrl_chk.sv
// Property checker, bound into the stall controller.
module pipe_stall_ctrl_chk #(
    parameter int ID_W  = 4,
    parameter int LAT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_busy,
    input logic             in_ready,
    input logic             ret_valid,
    input logic [ID_W-1:0]  ret_id,
    input logic             b1_valid,
    input logic [ID_W+LAT_W-1:0] b1_q,
    input logic             b2_valid,
    input logic [ID_W-1:0]  b2_id
);
    // R2: once execute is not busy, its token reaches the write stage at the next edge.
    a_r2_exec_done: assert property (@(posedge clk) disable iff (!rst_n)
        (b2_valid && !exec_busy) |=> (ret_valid && ret_id == $past(b2_id)));

    // R3: from the second busy cycle on, the write stage gets a bubble.
    a_r3_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_busy && $past(exec_busy)) |-> !ret_valid);

    // R4: the decode-to-execute buffer is frozen while busy.
    a_r4_de_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy |=> ($stable(b2_id) && b2_valid));

    // R5: the fetch-to-decode buffer is frozen while busy.
    a_r5_fd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy |=> ($stable(b1_q) && $stable(b1_valid)));

    // R5: a busy execute stage always holds a real token and refuses fetch.
    a_r5_busy_token: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy |-> (b2_valid && !in_ready));
endmodule

bind pipe_stall_ctrl pipe_stall_ctrl_chk #(.ID_W(ID_W), .LAT_W(LAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_busy(exec_busy), .in_ready(in_ready),
    .ret_valid(ret_valid), .ret_id(ret_id), .b1_valid(b1_valid), .b1_q(b1_q),
    .b2_valid(b2_valid), .b2_id(b2_id)
);

// File: tb/pipe_stall_ctrl_test.sv
module pipe_stall_ctrl_test;
    localparam int ID_W  = 4;
    localparam int LAT_W = 3;
    localparam int NTOK  = 3;
    localparam int NCYC  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [ID_W-1:0]  in_id = '0;
    logic [LAT_W-1:0] in_lat = '0;
    logic             in_ready, hold_fd, hold_de, exec_busy, ret_valid;
    logic [ID_W-1:0]  ret_id;

    int total = 0;
    int bad   = 0;
    int ticks = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pipe_stall_ctrl #(.ID_W(ID_W), .LAT_W(LAT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_lat(in_lat),
        .in_ready(in_ready), .hold_fd(hold_fd), .hold_de(hold_de), .exec_busy(exec_busy),
        .ret_valid(ret_valid), .ret_id(ret_id)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 100000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", ticks, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(input int l0, input int l1, input int l2, input int base);
        int lat[NTOK];
        int ids[NTOK];
        int eff[NTOK];
        int s[NTOK];
        int idx;
        bit fire;
        lat[0] = l0; lat[1] = l1; lat[2] = l2;
        for (int k = 0; k < NTOK; k++) begin
            ids[k] = (base + k) % (1 << ID_W);
            eff[k] = (lat[k] == 0) ? 1 : lat[k];
        end
        s[0] = 1;
        for (int k = 1; k < NTOK; k++) s[k] = s[k-1] + eff[k-1];

        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!ret_valid && !exec_busy && !hold_fd && !hold_de && in_ready,
              "R1", {ret_valid, exec_busy, hold_fd, hold_de, in_ready}, 1);

        idx = 0;
        fire = 0;
        for (int c = -1; c < NCYC; c++) begin
            if (c >= 0) begin
                bit exp_busy = 0;
                bit exp_ret = 0;
                int exp_id = 0;
                for (int k = 0; k < NTOK; k++) begin
                    if (c >= s[k] && c <= s[k] + eff[k] - 2) exp_busy = 1;
                    if (c == s[k] + eff[k]) begin
                        exp_ret = 1;
                        exp_id = ids[k];
                    end
                end
                // R5: fetch blocked and front holds exactly while busy
                check(in_ready == !exp_busy && hold_fd == exp_busy && hold_de == exp_busy,
                      "R5", {in_ready, hold_fd, hold_de}, {!exp_busy, exp_busy, exp_busy});
                // R2 R3 R6: retirement schedule, bubbles while a long token runs
                check(ret_valid == exp_ret, "R3_R6_schedule", ret_valid, exp_ret);
                // R4: the retiring token keeps its identity through the stall
                if (exp_ret)
                    check(ret_id == ID_W'(exp_id), "R4_R6_order", ret_id, exp_id);
            end
            if (fire) idx++;
            if (idx < NTOK) begin
                in_valid = 1'b1;
                in_id = ID_W'(ids[idx]);
                in_lat = LAT_W'(lat[idx]);
            end else begin
                in_valid = 1'b0;
            end
            fire = in_valid && in_ready;
            @(negedge clk);
        end
    endtask

    initial begin
        int n = 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int d = 0; d < 4; d++) begin
                    run(a, b, d, n);
                    n++;
                end
        // R2: a stream of single-cycle tokens retires back to back
        run(1, 1, 1, 7);
        // R3: longest latency at every position
        run(7, 7, 7, 2);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule